// File: doc/BRIEF.md
# SPI Memory Slave Front End with Transfer Pause

This block is the serial side of an SPI memory device. It is always a slave: the serial clock, chip select, pause input and serial data input all come from the bus master. Those four inputs are brought into a fast system clock through multi-flop synchronisers, and the block detects serial clock edges in that domain. Data is sampled on the serial clock rising edge. The output bit changes on the falling edge, which is SPI mode 0. Both directions send the most significant bit first.

The first byte of each select window is an opcode. A decoder sorts the opcode into a class. The class says whether address bytes follow and whether the data phase writes into the memory, reads from it, or carries nothing. Toward the memory-side model the block gives single-cycle strobes for the opcode, the completed address and each written byte. It also gives a read request each time it needs a new byte to send, and it expects that byte on `rd_data` before the next serial clock falling edge. An unknown opcode locks the frame until chip select is released. The active-low pause input freezes a transfer in place, so that the bus can serve another device and then continue where it stopped.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and at all times while `cs_n` is high, `so_en` is 0 and no strobe (`op_valid`, `addr_valid`, `wr_valid`, `rd_req`) is raised.
- R2: The first 8 bits after `cs_n` falls are taken MSB first as the opcode. A recognised opcode raises `op_valid` for one cycle with `op_code` equal to the byte. Recognised codes: 0x06, 0x04, 0x62 (no address, no data); 0x05 (read, no address); 0x01 (write, no address); 0x03 (address then read); 0x02 (address then write); 0x52 (address, no data).
- R3: For an opcode with an address, the next ADDR_BYTES bytes are assembled MSB first into `addr`, and `addr_valid` pulses once when the last address byte completes.
- R4: For a write-class opcode, every complete byte in the data phase raises `wr_valid` for one cycle with `wr_data` equal to that byte.
- R5: For a read-class opcode, `rd_req` pulses when the data phase starts and after every completed data byte. The byte on `rd_data` is sent MSB first on `so_d`, with a new bit after each serial clock falling edge, and `so_en` is 1 during the data phase.
- R6: After an unrecognised opcode, no strobe is raised and `so_en` stays 0 for the rest of the select window, whatever bytes follow.
- R7: If `cs_n` rises partway through a byte, the partial bits are dropped, and the next select window starts a fresh opcode at bit 7.
- R8: A fall of `hold_n` while `sck` is low pauses the transfer. During the pause, `so_en` is 0, serial clock edges and `si` are ignored, and the bit position is kept. A rise of `hold_n` while `sck` is low resumes the transfer from the bit where it stopped.
- R9: A transition of `hold_n` that happens while `sck` is high neither starts nor ends a pause.
- R10: Opcode 0x15 is a read-class opcode with no address when ID_EN is 1, and is unrecognised when ID_EN is 0. All other codes are unrecognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for so_d (0 means high impedance) |
| op_valid | output | 1 | One-cycle strobe for an accepted opcode |
| op_code | output | 8 | Last accepted opcode |
| addr_valid | output | 1 | One-cycle strobe when the address is complete |
| addr | output | 8*ADDR_BYTES | Assembled address |
| wr_valid | output | 1 | One-cycle strobe for each written byte |
| wr_data | output | 8 | Written byte |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte from the memory side to send |

## Verification
The bench builds the block with three address bytes, two synchroniser stages and the identification opcode enabled. With these values, every opcode class can be reached, including 0x15 as an accepted read. The serial clock half period of eight system cycles leaves room for the synchroniser delay and the one-cycle response of the memory model. A pause can therefore be placed a few cycles after a falling edge, and a `hold_n` transition can be placed in the middle of a high phase, so that both the qualifying and the ignored cases are exercised. The ID_EN=0 decoder variant is elaborated only as the alternative branch and is not driven.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   typedef enum logic [1:0] {ST_OPC, ST_ADDR, ST_DATA, ST_LOCK} slv_state_e;
   typedef enum logic [1:0] {DIR_NONE, DIR_RD, DIR_WR} slv_dir_e;

   typedef struct packed {
      logic     valid;
      logic     has_addr;
      slv_dir_e dir;
   } opc_info_t;

   localparam logic [7:0] OPC_WLATCH_SET = 8'h06;
   localparam logic [7:0] OPC_WLATCH_CLR = 8'h04;
   localparam logic [7:0] OPC_STAT_RD    = 8'h05;
   localparam logic [7:0] OPC_STAT_WR    = 8'h01;
   localparam logic [7:0] OPC_ARR_RD     = 8'h03;
   localparam logic [7:0] OPC_ARR_PROG   = 8'h02;
   localparam logic [7:0] OPC_SECT_ERASE = 8'h52;
   localparam logic [7:0] OPC_FULL_ERASE = 8'h62;
   localparam logic [7:0] OPC_IDENT_RD   = 8'h15;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   initial begin
      a_stages_min : assert (STAGES >= 2) else $error("STAGES must be at least 2");
      a_width_min  : assert (W >= 1) else $error("W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_hold.sv
module spi_slv_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   output logic held
);
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b1;
         held   <= 1'b0;
      end else begin
         hold_q <= hold_n_s;
         if (cs_n_s) begin
            held <= 1'b0;
         end else if (!sck_s) begin
            if (hold_q && !hold_n_s)      held <= 1'b1;
            else if (!hold_q && hold_n_s) held <= 1'b0;
         end
      end
   end

   // R8: a pause only begins on a pause-input fall seen with the clock low
   p_hold_entry_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> !$past(sck_s) && !$past(hold_n_s));

   // R9: a pause only ends with the clock low, or by deselection
   p_hold_exit_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held) |-> $past(cs_n_s) || !$past(sck_s));
endmodule

// File: rtl/spi_slv_decode.sv
module spi_slv_decode
   import spi_slv_pkg::*;
#(
   parameter bit ID_EN = 1'b1
) (
   input  logic [7:0] opcode,
   output opc_info_t  info
);
   logic id_hit;

   if (ID_EN) begin : g_id_on
      assign id_hit = (opcode == OPC_IDENT_RD);
   end else begin : g_id_off
      assign id_hit = 1'b0;
   end

   always_comb begin
      info = '{valid: 1'b0, has_addr: 1'b0, dir: DIR_NONE};
      case (opcode)
         OPC_WLATCH_SET, OPC_WLATCH_CLR, OPC_FULL_ERASE: info.valid = 1'b1;
         OPC_STAT_RD: begin
            info.valid = 1'b1;
            info.dir   = DIR_RD;
         end
         OPC_STAT_WR: begin
            info.valid = 1'b1;
            info.dir   = DIR_WR;
         end
         OPC_ARR_RD: begin
            info.valid    = 1'b1;
            info.has_addr = 1'b1;
            info.dir      = DIR_RD;
         end
         OPC_ARR_PROG: begin
            info.valid    = 1'b1;
            info.has_addr = 1'b1;
            info.dir      = DIR_WR;
         end
         OPC_SECT_ERASE: begin
            info.valid    = 1'b1;
            info.has_addr = 1'b1;
         end
         default: begin
            if (id_hit) begin
               info.valid = 1'b1;
               info.dir   = DIR_RD;
            end
         end
      endcase
   end
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
   import spi_slv_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int BC_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              held,
   input  logic              rise,
   input  logic              fall,
   input  logic              si_s,
   output logic [7:0]        byte_nxt,
   input  opc_info_t         info,
   output logic              op_valid,
   output logic [7:0]        op_code,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_valid,
   output logic [7:0]        wr_data,
   output logic              rd_req,
   input  logic [7:0]        rd_data,
   output logic              so_d,
   output logic              tx_on
);
   slv_state_e      state;
   slv_dir_e        cur_dir;
   logic [6:0]      shreg;
   logic [2:0]      bit_cnt;
   logic [BC_W-1:0] byte_cnt;
   logic [7:0]      tx;
   logic            load_pend;

   initial begin
      a_addr_bytes : assert (ADDR_BYTES >= 2 && ADDR_BYTES <= 4)
         else $error("ADDR_BYTES must be 2..4");
   end

   assign byte_nxt = {shreg, si_s};
   assign so_d     = tx[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_OPC;
         cur_dir    <= DIR_NONE;
         shreg      <= '0;
         bit_cnt    <= '0;
         byte_cnt   <= '0;
         tx         <= '0;
         tx_on      <= 1'b0;
         load_pend  <= 1'b0;
         op_valid   <= 1'b0;
         op_code    <= '0;
         addr_valid <= 1'b0;
         addr       <= '0;
         wr_valid   <= 1'b0;
         wr_data    <= '0;
         rd_req     <= 1'b0;
      end else begin
         op_valid   <= 1'b0;
         addr_valid <= 1'b0;
         wr_valid   <= 1'b0;
         rd_req     <= 1'b0;
         if (cs_n_s) begin
            state     <= ST_OPC;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            tx_on     <= 1'b0;
            load_pend <= 1'b0;
         end else if (!held) begin
            if (rise && state != ST_LOCK) begin
               shreg   <= byte_nxt[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  case (state)
                     ST_OPC: begin
                        if (!info.valid) begin
                           state <= ST_LOCK;
                        end else begin
                           op_valid <= 1'b1;
                           op_code  <= byte_nxt;
                           cur_dir  <= info.dir;
                           byte_cnt <= '0;
                           if (info.has_addr) begin
                              state <= ST_ADDR;
                           end else begin
                              state <= ST_DATA;
                              if (info.dir == DIR_RD) begin
                                 rd_req    <= 1'b1;
                                 load_pend <= 1'b1;
                              end
                           end
                        end
                     end
                     ST_ADDR: begin
                        addr     <= {addr[ADDR_W-9:0], byte_nxt};
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == BC_W'(ADDR_BYTES - 1)) begin
                           addr_valid <= 1'b1;
                           state      <= ST_DATA;
                           if (cur_dir == DIR_RD) begin
                              rd_req    <= 1'b1;
                              load_pend <= 1'b1;
                           end
                        end
                     end
                     ST_DATA: begin
                        if (cur_dir == DIR_WR) begin
                           wr_valid <= 1'b1;
                           wr_data  <= byte_nxt;
                        end else if (cur_dir == DIR_RD) begin
                           rd_req    <= 1'b1;
                           load_pend <= 1'b1;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            if (fall && state == ST_DATA && cur_dir == DIR_RD) begin
               if (load_pend) begin
                  tx        <= rd_data;
                  tx_on     <= 1'b1;
                  load_pend <= 1'b0;
               end else begin
                  tx <= {tx[6:0], 1'b0};
               end
            end
         end
      end
   end

   // R6: a locked frame raises nothing and drives nothing
   p_lock_silent_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_LOCK |-> !tx_on && !rd_req && !wr_valid && !addr_valid);

   // R2: the memory-side strobes never coincide
   p_strobe_excl_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_valid, addr_valid, wr_valid}));

   // R2: an opcode strobe only follows the opcode phase
   p_opc_first_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> $past(state) == ST_OPC);

   // R8: position and output byte are frozen during a pause
   p_hold_freeze_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      held && !cs_n_s |=> $stable(bit_cnt) && $stable(state) && $stable(tx));

   // R5: the output only switches on after a requested byte was pending
   p_tx_start_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_on) |-> $past(load_pend));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_slv_pkg::*;
#(
   parameter int  ADDR_BYTES  = 3,
   parameter int  SYNC_STAGES = 2,
   parameter bit  ID_EN       = 1'b1,
   localparam int ADDR_W      = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              si,
   output logic              so_d,
   output logic              so_en,
   output logic              op_valid,
   output logic [7:0]        op_code,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_valid,
   output logic [7:0]        wr_data,
   output logic              rd_req,
   input  logic [7:0]        rd_data
);
   logic       cs_n_s, hold_n_s, sck_s, si_s;
   logic       sck_q, rise, fall, held, tx_on;
   logic [7:0] byte_nxt;
   opc_info_t  info;

   spi_slv_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, hold_n, sck, si}),
      .q     ({cs_n_s, hold_n_s, sck_s, si_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign rise = sck_s & ~sck_q;
   assign fall = ~sck_s & sck_q;

   spi_slv_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (cs_n_s),
      .sck_s    (sck_s),
      .hold_n_s (hold_n_s),
      .held     (held)
   );

   spi_slv_decode #(.ID_EN(ID_EN)) u_dec (
      .opcode (byte_nxt),
      .info   (info)
   );

   spi_slv_engine #(.ADDR_BYTES(ADDR_BYTES)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (cs_n_s),
      .held       (held),
      .rise       (rise),
      .fall       (fall),
      .si_s       (si_s),
      .byte_nxt   (byte_nxt),
      .info       (info),
      .op_valid   (op_valid),
      .op_code    (op_code),
      .addr_valid (addr_valid),
      .addr       (addr),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .rd_req     (rd_req),
      .rd_data    (rd_data),
      .so_d       (so_d),
      .tx_on      (tx_on)
   );

   assign so_en = tx_on & ~held & ~cs_n_s;

   // R1: deselection of one cycle later leaves no strobe behind
   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s && $past(cs_n_s) |-> !op_valid && !addr_valid && !wr_valid && !rd_req);
endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int AB         = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
   logic        so_d, so_en, op_valid, addr_valid, wr_valid, rd_req;
   logic [7:0]  op_code, wr_data, rd_data;
   logic [8*AB-1:0] addr;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_mem_slave #(.ADDR_BYTES(AB), .SYNC_STAGES(2), .ID_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
      .so_d(so_d), .so_en(so_en), .op_valid(op_valid), .op_code(op_code),
      .addr_valid(addr_valid), .addr(addr), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd_data)
   );

   function automatic logic [7:0] pat(input logic [8*AB-1:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   // memory-side model and strobe monitor
   int          n_op = 0, n_addr = 0, n_wr = 0;
   logic [7:0]  last_op = '0;
   logic [8*AB-1:0] last_addr = '0, ptr = '0;
   logic [15:0] wr_hist = '0;
   logic        clr_seen = 1'b0, en_seen = 1'b0;

   always @(posedge clk) begin
      if (op_valid) begin n_op <= n_op + 1; last_op <= op_code; end
      if (addr_valid) begin n_addr <= n_addr + 1; last_addr <= addr; end
      if (wr_valid) begin n_wr <= n_wr + 1; wr_hist <= {wr_hist[7:0], wr_data}; end
      if (rd_req) begin
         rd_data <= pat(addr_valid ? addr : ptr);
         ptr     <= (addr_valid ? addr : ptr) + 1'b1;
      end else if (addr_valid) begin
         ptr <= addr;
      end
      if (clr_seen) en_seen <= 1'b0;
      else if (so_en) en_seen <= 1'b1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_bit(input logic b, output logic r, output logic e);
      si = b;
      wait_clk(HALF);
      r = so_d;
      e = so_en;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   // one bit with the pause input set to hv in the middle of the high phase
   task automatic bit_hold_high(input logic b, input logic hv);
      si = b;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF/2);
      hold_n = hv;
      wait_clk(HALF/2);
      sck = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output logic all_en);
      logic x, e;
      all_en = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         spi_bit(b[i], x, e);
         r[i] = x;
         all_en = all_en & e;
      end
   endtask

   task automatic cs_lo();
      clr_seen = 1'b1;
      wait_clk(1);
      clr_seen = 1'b0;
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_hi();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2*HALF);
   endtask

   task automatic pause_toggle(input int n);
      wait_clk(4);
      hold_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         si = ~si;
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
         wait_clk(HALF);
      end
   endtask

   // opcode, accepted
   localparam int NV = 14;
   localparam logic [8:0] VEC [NV] = '{
      {8'h06, 1'b1}, {8'h04, 1'b1}, {8'h05, 1'b1}, {8'h01, 1'b1},
      {8'h03, 1'b1}, {8'h02, 1'b1}, {8'h52, 1'b1}, {8'h62, 1'b1},
      {8'h15, 1'b1}, {8'h00, 1'b0}, {8'hFF, 1'b0}, {8'h0B, 1'b0},
      {8'h9F, 1'b0}, {8'hD8, 1'b0}
   };

   initial begin
      repeat (200000) @(negedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, rb;
      logic en, x, e, all_e;
      int op0, ad0, wr0;

      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1: reset state
      chk("R1 so_en after reset", so_en, 0);
      chk("R1 strobes after reset", {op_valid, addr_valid, wr_valid, rd_req}, 0);

      // R2 R6 R10: opcode table walk
      for (int k = 0; k < NV; k++) begin
         op0 = n_op; ad0 = n_addr; wr0 = n_wr;
         cs_lo();
         spi_byte(VEC[k][8:1], r, en);
         spi_byte(8'h03, r, en);
         spi_byte(8'h06, r, en);
         spi_byte(8'h02, r, en);
         cs_hi();
         chk($sformatf("R2 R10 accept count op %0h", VEC[k][8:1]), n_op - op0, {31'd0, VEC[k][0]});
         if (VEC[k][0]) begin
            chk("R2 opcode value", last_op, VEC[k][8:1]);
         end else begin
            chk("R6 locked no strobes", (n_addr - ad0) + (n_wr - wr0), 0);
            chk("R6 locked so_en", en_seen, 0);
         end
         chk("R1 so_en after deselect", so_en, 0);
      end

      // R3 R4: program with address and two data bytes
      op0 = n_op; wr0 = n_wr;
      cs_lo();
      spi_byte(8'h02, r, en);
      spi_byte(8'h12, r, en);
      spi_byte(8'h34, r, en);
      spi_byte(8'h56, r, en);
      spi_byte(8'hC3, r, en);
      spi_byte(8'h3C, r, en);
      cs_hi();
      chk("R3 address assembled", last_addr, 24'h123456);
      chk("R4 write count", n_wr - wr0, 2);
      chk("R4 write bytes", wr_hist, 16'hC33C);

      // R5: array read of three bytes
      cs_lo();
      spi_byte(8'h03, r, en);
      spi_byte(8'h00, r, en);
      spi_byte(8'h00, r, en);
      spi_byte(8'h10, r, en);
      for (int i = 0; i < 3; i++) begin
         spi_byte(8'h00, rb, all_e);
         chk($sformatf("R5 read byte %0d", i), rb, pat(24'h10 + i));
         chk("R5 so_en in read", all_e, 1);
      end
      cs_hi();
      chk("R1 so_en after read", so_en, 0);

      // R7: deselect mid-byte drops partial bits
      op0 = n_op;
      cs_lo();
      for (int i = 0; i < 4; i++) spi_bit(1'b1, x, e);
      cs_hi();
      cs_lo();
      spi_byte(8'h06, r, en);
      cs_hi();
      chk("R7 fresh opcode count", n_op - op0, 1);
      chk("R7 fresh opcode value", last_op, 8'h06);

      // R8: pause mid-address in a program frame, si toggling
      wr0 = n_wr;
      cs_lo();
      spi_byte(8'h02, r, en);
      spi_byte(8'h12, r, en);
      for (int i = 7; i >= 4; i--) spi_bit(r_bit(8'h34, i), x, e);
      pause_toggle(3);
      hold_n = 1'b1;
      wait_clk(HALF);
      for (int i = 3; i >= 0; i--) spi_bit(r_bit(8'h34, i), x, e);
      spi_byte(8'h56, r, en);
      spi_byte(8'h77, r, en);
      cs_hi();
      chk("R8 address across pause", last_addr, 24'h123456);
      chk("R8 write across pause", wr_hist[7:0], 8'h77);

      // R8: pause during a read data byte
      cs_lo();
      spi_byte(8'h03, r, en);
      spi_byte(8'h00, r, en);
      spi_byte(8'h00, r, en);
      spi_byte(8'h40, r, en);
      for (int i = 7; i >= 4; i--) begin spi_bit(1'b0, x, e); rb[i] = x; end
      pause_toggle(2);
      chk("R8 so_en during pause", so_en, 0);
      hold_n = 1'b1;
      wait_clk(HALF);
      chk("R8 so_en after resume", so_en, 1);
      for (int i = 3; i >= 0; i--) begin spi_bit(1'b0, x, e); rb[i] = x; end
      cs_hi();
      chk("R8 read byte across pause", rb, pat(24'h40));

      // R9: pause-input transitions while sck high are ignored
      wr0 = n_wr;
      cs_lo();
      spi_byte(8'h02, r, en);
      spi_byte(8'h00, r, en);
      spi_byte(8'hAB, r, en);
      spi_bit(1'b1, x, e);
      spi_bit(1'b1, x, e);
      bit_hold_high(1'b0, 1'b0);
      spi_bit(1'b0, x, e);
      spi_bit(1'b1, x, e);
      bit_hold_high(1'b1, 1'b1);
      spi_bit(1'b0, x, e);
      spi_bit(1'b1, x, e);
      spi_byte(8'h5E, r, en);
      cs_hi();
      chk("R9 address unaffected", last_addr, 24'h00ABCD);
      chk("R9 write unaffected", n_wr - wr0, 1);
      chk("R9 write value", wr_hist[7:0], 8'h5E);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic r_bit(input logic [7:0] v, input int i);
      return v[i];
   endfunction
endmodule